// File: doc/BRIEF.md
# Telegram Field Receiver with Framing Check

This block sits behind a symbol slicer on a single-wire serial bus. It takes one already classified symbol per strobe: a zero bit, a one bit or a separator. From that stream it rebuilds the fields of a telegram. It waits for a run of separators and takes the next bit as the start of an address. It then shifts the address in, most significant bit first. When a separator closes the address, the block compares both the value and the bit count against a programmed address. Because addresses have no fixed size, a value that matches with a different length is not accepted.

After a matching address, the block collects each data field that follows a single separator. For each field it reports the field's word, right-aligned, and its bit count. Two separators in a row close the telegram and put the block back into its hunting state. A programmed data length, when not zero, is checked against every received data field. A field longer than the shift register also raises a framing error and drops the telegram.

Top module: `tfr_rx_top`

## Requirements
- R1: After reset, every strobe, `addr_match`, `data_word` and `data_len` are zero, and the block is hunting for an address.
- R2: In the hunting state, a bit starts an address only if at least two separators came right before it, with no bit between them. Bits after a shorter run are dropped, and the separator after them gives no `addr_done`.
- R3: A separator that closes an address pulses `addr_done` in the next cycle. `addr_match` is 1 only when the bit count equals `exp_addr_len` and the bits equal the low `exp_addr_len` bits of `exp_addr`. `addr_match` holds until the next `addr_done`.
- R4: After a non-matching address the block goes back to hunting, and no data field is reported until a new address matches.
- R5: After a matching address and one separator, data bits are collected MSB first. The separator that closes the field pulses `data_done` in the next cycle, with `data_word` right-aligned and `data_len` equal to the bit count. Both are held until the next `data_done`.
- R6: Several data fields, each closed by a single separator, are each reported in order.
- R7: Two separators in a row end the telegram without any strobe. A bit right after them starts a new address.
- R8: When `exp_data_len` is not zero and a data field's count differs from it, `frame_err` pulses together with that field's `data_done`. A value of zero turns the check off.
- R9: A bit that arrives when a field already holds FIELD_W (32) bits pulses `frame_err`, drops the field and returns to hunting. A new separator run is then needed.
- R10: Symbol code 2'b11 (reserved) is ignored. It neither breaks a separator run nor changes any field.
- R11: When `sym_valid` is low, nothing changes and all strobes are low in the next cycle.

Symbol codes on `sym_kind`: 2'b00 zero bit, 2'b01 one bit, 2'b10 separator, 2'b11 reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sym_valid | input | 1 | A symbol is present this cycle |
| sym_kind | input | 2 | Symbol code (00 zero, 01 one, 10 separator, 11 reserved) |
| exp_addr | input | 32 | Expected address, right-aligned |
| exp_addr_len | input | 6 | Expected address bit count |
| exp_data_len | input | 6 | Expected data bit count, 0 disables the check |
| addr_done | output | 1 | An address field has closed |
| addr_match | output | 1 | Result of the last address comparison |
| data_done | output | 1 | A data field has closed |
| data_word | output | 32 | Last data field, right-aligned |
| data_len | output | 6 | Bit count of the last data field |
| frame_err | output | 1 | Overflow or data length mismatch |

## Verification
The hardest situations to reach are the ones that depend on history. These are a bit preceded by exactly one separator, a reserved code inside a separator run, and a field that overflows by exactly one bit. Directed sequences build each of these symbol by symbol. A seeded random telegram generator then mixes short separator runs, addresses with extra leading zeros, wrong lengths, stray reserved codes and oversize fields. Its results are compared against a per-symbol reference model in the bench.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_SEP  = 2'b10,
        SYM_RSVD = 2'b11
    } sym_kind_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'b00,
        ST_ADDR = 2'b01,
        ST_DATA = 2'b10
    } rx_state_e;
endpackage

// File: rtl/tfr_sep_run.sv
module tfr_sep_run #(
    parameter int RUN_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sep_hit,
    input  logic bit_hit,
    output logic run_ok
);
    localparam int CW = $clog2(RUN_MIN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bit_hit) begin
            cnt_d = '0;
        end else if (sep_hit && (cnt_q < CW'(RUN_MIN))) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign run_ok = (cnt_q >= CW'(RUN_MIN));

    // R2
    bit_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_hit |=> !run_ok);
endmodule

// File: rtl/tfr_field_acc.sv
module tfr_field_acc #(
    parameter int W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     shift,
    input  logic                     clear,
    input  logic                     bit_in,
    output logic [W-1:0]             val,
    output logic [$clog2(W+1)-1:0]   len,
    output logic                     full
);
    localparam int LW = $clog2(W + 1);

    logic [W-1:0]  val_d, val_q;
    logic [LW-1:0] len_d, len_q;

    always_comb begin
        val_d = val_q;
        len_d = len_q;
        if (load) begin
            val_d = {{(W-1){1'b0}}, bit_in};
            len_d = LW'(1);
        end else if (shift) begin
            val_d = {val_q[W-2:0], bit_in};
            len_d = len_q + LW'(1);
        end else if (clear) begin
            val_d = '0;
            len_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            len_q <= '0;
        end else begin
            val_q <= val_d;
            len_q <= len_d;
        end
    end

    assign val  = val_q;
    assign len  = len_q;
    assign full = (len_q == LW'(W));

    // R9
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LW'(W));
    // R5
    shift_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (len_q == $past(len_q) + LW'(1)));
endmodule

// File: rtl/tfr_addr_cmp.sv
module tfr_addr_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0]           rx_val,
    input  logic [$clog2(W+1)-1:0] rx_len,
    input  logic [W-1:0]           ref_val,
    input  logic [$clog2(W+1)-1:0] ref_len,
    output logic                   hit
);
    localparam int LW = $clog2(W + 1);

    logic [W-1:0] keep;

    for (genvar i = 0; i < W; i++) begin : g_keep
        assign keep[i] = (LW'(i) < ref_len);
    end

    assign hit = (rx_len == ref_len) && (rx_val == (ref_val & keep));
endmodule

// File: rtl/tfr_rx_top.sv
module tfr_rx_top
    import tfr_pkg::*;
#(
    parameter int FIELD_W = 32,
    parameter int SEP_RUN = 2,
    localparam int LW = $clog2(FIELD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_valid,
    input  logic [1:0]         sym_kind,
    input  logic [FIELD_W-1:0] exp_addr,
    input  logic [LW-1:0]      exp_addr_len,
    input  logic [LW-1:0]      exp_data_len,
    output logic               addr_done,
    output logic               addr_match,
    output logic               data_done,
    output logic [FIELD_W-1:0] data_word,
    output logic [LW-1:0]      data_len,
    output logic               frame_err
);
    typedef struct packed {
        rx_state_e          st;
        logic               addr_done;
        logic               addr_match;
        logic               data_done;
        logic [FIELD_W-1:0] word;
        logic [LW-1:0]      dlen;
        logic               err;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic               sep_hit, bit_hit, bit_val;
    logic               run_ok;
    logic               acc_load, acc_shift, acc_clear;
    logic [FIELD_W-1:0] acc_val;
    logic [LW-1:0]      acc_len;
    logic               acc_full;
    logic               addr_hit;

    assign sep_hit = sym_valid && (sym_kind == SYM_SEP);
    assign bit_hit = sym_valid && !sym_kind[1];
    assign bit_val = sym_kind[0];

    tfr_sep_run #(.RUN_MIN(SEP_RUN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .sep_hit (sep_hit),
        .bit_hit (bit_hit),
        .run_ok  (run_ok)
    );

    tfr_field_acc #(.W(FIELD_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (acc_load),
        .shift  (acc_shift),
        .clear  (acc_clear),
        .bit_in (bit_val),
        .val    (acc_val),
        .len    (acc_len),
        .full   (acc_full)
    );

    tfr_addr_cmp #(.W(FIELD_W)) u_cmp (
        .rx_val  (acc_val),
        .rx_len  (acc_len),
        .ref_val (exp_addr),
        .ref_len (exp_addr_len),
        .hit     (addr_hit)
    );

    always_comb begin
        r_d           = r_q;
        r_d.addr_done = 1'b0;
        r_d.data_done = 1'b0;
        r_d.err       = 1'b0;
        acc_load      = 1'b0;
        acc_shift     = 1'b0;
        acc_clear     = 1'b0;
        unique case (r_q.st)
            ST_HUNT: begin
                if (bit_hit && run_ok) begin
                    acc_load = 1'b1;
                    r_d.st   = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (bit_hit) begin
                    if (acc_full) begin
                        r_d.err   = 1'b1;
                        acc_clear = 1'b1;
                        r_d.st    = ST_HUNT;
                    end else begin
                        acc_shift = 1'b1;
                    end
                end else if (sep_hit) begin
                    r_d.addr_done  = 1'b1;
                    r_d.addr_match = addr_hit;
                    acc_clear      = 1'b1;
                    r_d.st         = addr_hit ? ST_DATA : ST_HUNT;
                end
            end
            ST_DATA: begin
                if (bit_hit) begin
                    if (acc_full) begin
                        r_d.err   = 1'b1;
                        acc_clear = 1'b1;
                        r_d.st    = ST_HUNT;
                    end else begin
                        acc_shift = 1'b1;
                    end
                end else if (sep_hit) begin
                    if (acc_len == '0) begin
                        r_d.st = ST_HUNT;
                    end else begin
                        r_d.data_done = 1'b1;
                        r_d.word      = acc_val;
                        r_d.dlen      = acc_len;
                        r_d.err       = (exp_data_len != '0) && (acc_len != exp_data_len);
                        acc_clear     = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_HUNT, word: '0, dlen: '0, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_done  = r_q.addr_done;
    assign addr_match = r_q.addr_match;
    assign data_done  = r_q.data_done;
    assign data_word  = r_q.word;
    assign data_len   = r_q.dlen;
    assign frame_err  = r_q.err;

    // R3
    addr_after_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> $past(sym_valid && (sym_kind == SYM_SEP)));
    // R7
    data_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |-> (data_len != '0));
    // R9
    err_vs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !addr_done);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> (!addr_done && !data_done && !frame_err));
    // R5
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_done |-> $stable(data_word));
endmodule

// File: tb/sim_tfr_rx_top.sv
`timescale 1ns/1ps
module sim_tfr_rx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [1:0]  sym_kind = 2'b00;
    logic [31:0] exp_addr = '0;
    logic [5:0]  exp_addr_len = '0;
    logic [5:0]  exp_data_len = '0;
    logic        addr_done, addr_match, data_done, frame_err;
    logic [31:0] data_word;
    logic [5:0]  data_len;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    // reference model state
    int          m_st = 0;    // 0 hunt, 1 address, 2 data
    int          m_run = 0;
    logic [31:0] m_val = '0;
    int          m_len = 0;
    logic        e_ad = 0, e_am = 0, e_dd = 0, e_err = 0;
    logic [31:0] e_word = '0;
    int          e_dlen = 0;

    always #2 clk = ~clk;

    tfr_rx_top u0 (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_kind(sym_kind),
        .exp_addr(exp_addr), .exp_addr_len(exp_addr_len), .exp_data_len(exp_data_len),
        .addr_done(addr_done), .addr_match(addr_match), .data_done(data_done),
        .data_word(data_word), .data_len(data_len), .frame_err(frame_err)
    );

    function automatic logic [31:0] low_mask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic [1:0] k);
        e_ad = 0; e_dd = 0; e_err = 0;
        if (k == 2'b11) return;
        if (k == 2'b10) begin
            if (m_st == 1) begin
                e_ad = 1;
                e_am = (m_len == int'(exp_addr_len)) && (m_val == (exp_addr & low_mask(m_len)));
                m_st = e_am ? 2 : 0;
                m_len = 0; m_val = '0;
            end else if (m_st == 2) begin
                if (m_len == 0) m_st = 0;
                else begin
                    e_dd = 1; e_word = m_val; e_dlen = m_len;
                    e_err = (exp_data_len != 0) && (m_len != int'(exp_data_len));
                    m_len = 0; m_val = '0;
                end
            end
            if (m_run < 2) m_run++;
        end else begin
            if (m_st == 0) begin
                if (m_run >= 2) begin m_st = 1; m_val = {31'b0, k[0]}; m_len = 1; end
            end else if (m_len == 32) begin
                e_err = 1; m_st = 0; m_len = 0; m_val = '0;
            end else begin
                m_val = {m_val[30:0], k[0]}; m_len++;
            end
            m_run = 0;
        end
    endtask

    task automatic compare_all();
        chk(addr_done === e_ad, "R2 addr_done", 32'(addr_done), 32'(e_ad));
        chk(addr_match === e_am, "R3 addr_match", 32'(addr_match), 32'(e_am));
        chk(data_done === e_dd, "R5 data_done", 32'(data_done), 32'(e_dd));
        chk(data_word === e_word, "R6 data_word", data_word, e_word);
        chk(int'(data_len) == e_dlen, "R6 data_len", 32'(data_len), 32'(e_dlen));
        chk(frame_err === e_err, "R8 frame_err", 32'(frame_err), 32'(e_err));
    endtask

    task automatic send_sym(input logic [1:0] k);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_kind  = k;
        model_step(k);
        @(negedge clk);
        sym_valid = 1'b0;
        compare_all();
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_sym({1'b0, v[i]});
    endtask

    task automatic send_r(input logic [1:0] k);
        if ($urandom % 20 == 0) send_sym(2'b11);
        send_sym(k);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!addr_done && !addr_match && !data_done && !frame_err, "R1 strobes", 32'(addr_done | data_done | frame_err), 0);
        chk(data_word == 0 && data_len == 0, "R1 data", data_word, 0);

        exp_addr = 32'h5; exp_addr_len = 6'd3; exp_data_len = 6'd0;
        // R2: a single separator is not enough
        send_sym(2'b10); send_bits(32'h5, 3); send_sym(2'b10);
        chk(addr_done == 0, "R2 short run", 32'(addr_done), 0);
        send_sym(2'b10); send_bits(32'h5, 3); send_sym(2'b10);
        chk(addr_done && addr_match, "R3 exact match", 32'(addr_match), 1);
        send_bits(32'h6, 3); send_sym(2'b10);
        chk(data_done && data_word == 32'h6 && data_len == 3, "R5 first field", data_word, 32'h6);
        send_bits(32'h1, 1); send_sym(2'b10);
        chk(data_done && data_word == 32'h1 && data_len == 1, "R6 second field", data_word, 32'h1);
        // R7: double separator ends telegram, next bit starts address
        send_sym(2'b10);
        chk(!data_done && !addr_done, "R7 end no strobe", 32'(data_done), 0);
        send_bits(32'h5, 3); send_sym(2'b10);
        chk(addr_done && addr_match, "R7 back-to-back address", 32'(addr_match), 1);
        send_sym(2'b10);
        // R3: leading zero changes length
        send_sym(2'b10); send_bits(32'h5, 4); send_sym(2'b10);
        chk(addr_done && !addr_match, "R3 length differs", 32'(addr_match), 0);
        // R4: no data after mismatch
        send_bits(32'h3, 2); send_sym(2'b10);
        chk(!data_done, "R4 no data after mismatch", 32'(data_done), 0);
        send_sym(2'b10); send_sym(2'b10);
        // R8 data length check
        exp_data_len = 6'd2;
        send_bits(32'h5, 3); send_sym(2'b10);
        send_bits(32'h7, 3); send_sym(2'b10);
        chk(data_done && frame_err, "R8 length mismatch", 32'(frame_err), 1);
        send_bits(32'h2, 2); send_sym(2'b10);
        chk(data_done && !frame_err, "R8 length ok", 32'(frame_err), 0);
        send_sym(2'b10);
        exp_data_len = 6'd0;
        // R9 overflow at bit 33
        send_sym(2'b10); send_sym(2'b10);
        for (int i = 0; i < 32; i++) send_sym(2'b01);
        chk(!frame_err, "R9 32 bits fit", 32'(frame_err), 0);
        send_sym(2'b01);
        chk(frame_err, "R9 overflow", 32'(frame_err), 1);
        send_sym(2'b10);
        chk(!addr_done, "R9 dropped field", 32'(addr_done), 0);
        // R10 reserved inside run and field
        send_sym(2'b10); send_sym(2'b11); send_sym(2'b10);
        send_bits(32'h1, 1); send_sym(2'b11); send_bits(32'h1, 2); send_sym(2'b11); send_sym(2'b10);
        chk(addr_done && addr_match, "R10 reserved ignored", 32'(addr_match), 1);
        send_sym(2'b10); send_sym(2'b10);
        // R11 idle
        repeat (3) @(negedge clk);
        chk(!addr_done && !data_done && !frame_err, "R11 idle", 32'(addr_done | data_done | frame_err), 0);

        // random telegrams
        for (int t = 0; t < 300; t++) begin
            int run_n, nf;
            logic [31:0] a;
            int al;
            exp_addr_len = 6'(1 + $urandom % 8);
            exp_addr = $urandom & low_mask(int'(exp_addr_len));
            exp_data_len = ($urandom % 3 == 0) ? 6'd0 : 6'(1 + $urandom % 6);
            run_n = ($urandom % 10 == 0) ? 1 : 2 + $urandom % 3;
            for (int i = 0; i < run_n; i++) send_r(2'b10);
            case ($urandom % 4)
                0: begin al = int'(exp_addr_len) + 1; a = exp_addr; end
                1: begin al = 1 + $urandom % 9; a = $urandom & low_mask(al); end
                default: begin al = int'(exp_addr_len); a = exp_addr; end
            endcase
            for (int i = al - 1; i >= 0; i--) send_r({1'b0, a[i]});
            send_r(2'b10);
            nf = 1 + $urandom % 3;
            for (int f = 0; f < nf; f++) begin
                int dl;
                logic [31:0] d;
                dl = ($urandom % 25 == 0) ? 33 + $urandom % 3 : 1 + $urandom % 8;
                d = $urandom;
                for (int i = dl - 1; i >= 0; i--) send_r({1'b0, (i < 32) ? d[i] : 1'b1});
                send_r(2'b10);
            end
            for (int i = 0; i < 2 + $urandom % 2; i++) send_r(2'b10);
            if ($urandom % 8 == 0) repeat (2) @(negedge clk);
        end
        done_flag = 1'b1;
        finish_run();
    end
endmodule